// File: doc/BRIEF.md
# I2C START generator with stuck-SDA recovery

This block is the part of an I2C master that opens a transfer. Software raises a one-cycle request. The block keeps that request pending until the bus may be taken. It then produces a START condition on the open-drain SDA and SCL lines, using pull-low enables. The same path serves a first START, a repeated START and a START forced after a bus timeout. Upstream logic decides which case applies and signals it by asserting `bus_free_i`.

Another device may be holding SDA low when the block is ready to issue the START. In that case the block does not give up. It clocks SCL with extra pulses and samples SDA again after every second pulse. Once SDA reads high, it issues an ordinary START. Software takes no part in this recovery. It sees the pending request clear, the interrupt flag rise and the status read 08h.

SCL held low by someone else cannot be fixed from here. The block drives nothing and waits for SCL to be released. A separate timer raises a sticky flag when SCL stays low for too long.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset both pull-low enables are off, the interrupt flag, the pending request and the stuck flag are 0, and the status reads 5'h1F.
- R2: A request pulse on `sta_set_i` makes `sta_pending_o` 1. While `bus_free_i` is low, the block drives neither line and the request stays pending.
- R3: Once a pending request meets `bus_free_i` high, both lines stay released. This lasts one cycle plus HALF_CNT cycles in which `scl_i` reads high. At the end of that time SDA is sampled.
- R4: If SDA is high at that sample, SDA is pulled low with SCL released for HOLD_CNT cycles, and then SCL is pulled low as well. In the cycle SCL is pulled low, `int_o` becomes 1, `status_o` becomes 5'h08 and `sta_pending_o` becomes 0.
- R5: If SDA is low at that sample, SCL is pulsed instead: low for HALF_CNT cycles, then released for HALF_CNT cycles. SDA stays released throughout the pulses.
- R6: SDA is sampled again only after each second extra pulse. If it is high, a START follows as in R4. If it is low, two more pulses follow.
- R7: In the released half of an extra pulse, cycles in which `scl_i` reads low are not counted. This lets another device stretch the clock.
- R8: While another device holds SCL low, the block drives neither line and takes no step of the START or pulse sequence.
- R9: If SCL reads low, without the block pulling it, for STUCK_LIM consecutive cycles while a START is in progress, `scl_stuck_o` becomes 1. It stays 1 until `int_clr_i`.
- R10: `int_clr_i` clears `int_o` and `scl_stuck_o`. After a START, it also releases both lines and returns the status to 5'h1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sta_set_i | input | 1 | One-cycle START request from software |
| bus_free_i | input | 1 | The bus may be taken (free, forced or own repeated START) |
| int_clr_i | input | 1 | Clears the interrupt and stuck flags |
| sda_i | input | 1 | Sampled SDA level |
| scl_i | input | 1 | Sampled SCL level |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| status_o | output | 5 | 5'h08 after a START, 5'h1F otherwise |
| sta_pending_o | output | 1 | START request still pending |
| int_o | output | 1 | Interrupt flag, set on a successful START |
| scl_stuck_o | output | 1 | Sticky flag: SCL held low beyond STUCK_LIM |

## Verification
The bench builds the block with HALF_CNT = 4, HOLD_CNT = 3 and STUCK_LIM = 12. With these values a whole START, several recovery pulse pairs and a stuck-SCL timeout each take only a few dozen cycles. The short half period makes it easy to land a clock stretch inside the released half of a pulse. It also lets the bench release SDA between the first and the second pulse pair, so the failed retry after two pulses and the successful retry after four both occur. The small stuck limit lets one held-SCL episode cross the threshold and then go on to a normal START.

// File: rtl/i2c_stgen_pkg.sv
package i2c_stgen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_DONE,
    ST_PLO,
    ST_PHI
  } stg_state_e;

  localparam logic [4:0] STAT_NONE    = 5'h1F;
  localparam logic [4:0] STAT_STARTED = 5'h08;
endpackage

// File: rtl/i2c_stgen_tick.sv
module i2c_stgen_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == lim_i);

  // R3: the controller never advances the counter past its limit
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |-> !hit_o);
endmodule

// File: rtl/i2c_stgen_stuck.sv
module i2c_stgen_stuck #(
  parameter int LIM = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic scl_oe_i,
  input  logic scl_i,
  input  logic clr_i,
  output logic stuck_o
);
  localparam int W = $clog2(LIM + 1);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic [W-1:0] run_q, run_d;
  logic         flag_q, flag_d;
  logic         watch, set;

  assign watch = active_i && !scl_oe_i && !scl_i;
  assign set   = watch && (run_q == LAST);

  always_comb begin
    if (!watch)       run_d = '0;
    else if (set)     run_d = run_q;
    else              run_d = run_q + 1'b1;
    flag_d = (flag_q && !clr_i) || set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign stuck_o = flag_q;

  // R9: the flag is sticky until cleared
  p_stuck_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_o && !clr_i) |=> stuck_o);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_stgen_pkg::*;
#(
  parameter int HALF_CNT  = 1000,
  parameter int HOLD_CNT  = 800,
  parameter int STUCK_LIM = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sta_set_i,
  input  logic       bus_free_i,
  input  logic       int_clr_i,
  input  logic       sda_i,
  input  logic       scl_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic [4:0] status_o,
  output logic       sta_pending_o,
  output logic       int_o,
  output logic       scl_stuck_o
);
  localparam int MAXC = (HALF_CNT > HOLD_CNT) ? HALF_CNT : HOLD_CNT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CNT - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CNT - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  stg_state_e state_q, state_d;
  logic       pair_q, pair_d;
  logic       req_q, req_d;
  logic       int_q, int_d;
  logic [4:0] stat_q, stat_d;
  logic       cnt_clr, cnt_en, cnt_hit, start_done;
  logic [CW-1:0] cnt_lim;

  assign cnt_lim = (state_q == ST_HOLD) ? HOLD_LAST : HALF_LAST;

  i2c_stgen_tick #(.W(CW)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .lim_i (cnt_lim),
    .hit_o (cnt_hit)
  );

  always_comb begin
    state_d    = state_q;
    pair_d     = pair_q;
    cnt_clr    = 1'b0;
    cnt_en     = 1'b0;
    start_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (req_q && bus_free_i) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (scl_i) begin
          if (cnt_hit) begin
            cnt_clr = 1'b1;
            pair_d  = 1'b0;
            state_d = sda_i ? ST_HOLD : ST_PLO;
          end else begin
            cnt_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_hit) begin
          cnt_clr    = 1'b1;
          start_done = 1'b1;
          state_d    = ST_DONE;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_DONE: begin
        cnt_clr = 1'b1;
        if (int_clr_i) state_d = ST_IDLE;
      end
      ST_PLO: begin
        if (cnt_hit) begin
          cnt_clr = 1'b1;
          state_d = ST_PHI;
        end else begin
          cnt_en = 1'b1;
        end
      end
      ST_PHI: begin
        if (scl_i) begin
          if (cnt_hit) begin
            cnt_clr = 1'b1;
            if (!pair_q) begin
              pair_d  = 1'b1;
              state_d = ST_PLO;
            end else begin
              pair_d  = 1'b0;
              state_d = sda_i ? ST_HOLD : ST_PLO;
            end
          end else begin
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    req_d  = sta_set_i || (req_q && !start_done);
    int_d  = start_done || (int_q && !int_clr_i);
    stat_d = stat_q;
    if (start_done)                            stat_d = STAT_STARTED;
    else if (state_q == ST_DONE && int_clr_i)  stat_d = STAT_NONE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pair_q  <= 1'b0;
      req_q   <= 1'b0;
      int_q   <= 1'b0;
      stat_q  <= STAT_NONE;
    end else begin
      state_q <= state_d;
      pair_q  <= pair_d;
      req_q   <= req_d;
      int_q   <= int_d;
      stat_q  <= stat_d;
    end
  end

  i2c_stgen_stuck #(.LIM(STUCK_LIM)) u_stuck (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active_i (state_q != ST_IDLE),
    .scl_oe_i (scl_oe_o),
    .scl_i    (scl_i),
    .clr_i    (int_clr_i),
    .stuck_o  (scl_stuck_o)
  );

  assign sda_oe_o      = (state_q == ST_HOLD) || (state_q == ST_DONE);
  assign scl_oe_o      = (state_q == ST_PLO)  || (state_q == ST_DONE);
  assign status_o      = stat_q;
  assign sta_pending_o = req_q;
  assign int_o         = int_q;

  // R4: SDA falls only after SCL was released in the previous cycle
  p_start_edge_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sda_oe_o) |-> (!scl_oe_o && $past(scl_i)));
  // R4: interrupt implies the started status
  p_int_status_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int_o |-> (status_o == STAT_STARTED));
  // R4: request retired together with the interrupt
  p_req_retire_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(int_o) && !$past(sta_set_i)) |-> !sta_pending_o);
  // R5: SDA released while an extra pulse pulls SCL
  p_pulse_sda_free_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (scl_oe_o && !int_o) |-> !sda_oe_o);
  // R8: no drive while SCL is held low during setup
  p_scl_wait_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SETUP && !scl_i) |=> (!scl_oe_o && !sda_oe_o));
  // R10: clear releases the bus after a START
  p_clear_release_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int_clr_i && int_o) |=> (!int_o && !sda_oe_o && !scl_oe_o));
endmodule

// File: tb/tb_i2c_start_gen.sv
`timescale 1ns/1ps
module tb_i2c_start_gen;
  localparam int HALF = 4;
  localparam int HOLD = 3;
  localparam int LIM  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sta_set = 1'b0, bus_free = 1'b0, int_clr = 1'b0;
  logic hold_sda = 1'b0, hold_scl = 1'b0;
  logic sda_oe, scl_oe, pending, intf, stuck;
  logic [4:0] status;
  wire  sda_bus = !(sda_oe || hold_sda);
  wire  scl_bus = !(scl_oe || hold_scl);

  always #2.5 clk = ~clk;

  i2c_start_gen #(.HALF_CNT(HALF), .HOLD_CNT(HOLD), .STUCK_LIM(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .sta_set_i(sta_set), .bus_free_i(bus_free),
    .int_clr_i(int_clr), .sda_i(sda_bus), .scl_i(scl_bus),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .status_o(status),
    .sta_pending_o(pending), .int_o(intf), .scl_stuck_o(stuck));

  int errors = 0, checks = 0, cyc = 0;
  string cur = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle,1 setup,2 hold,3 started,4 pulse low,5 pulse high
  int   m_phase, m_left, m_run, nxt;
  bit   m_second, m_req, m_int, m_stuck, done_now, watch;
  logic [4:0] m_stat;

  function automatic bit e_sda(input int p); return (p == 2 || p == 3); endfunction
  function automatic bit e_scl(input int p); return (p == 3 || p == 4); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_second = 0; m_req = 0; m_int = 0;
      m_stat = 5'h1F; m_run = 0; m_stuck = 0;
    end else begin
      cyc++;
      done_now = 0;
      nxt = m_phase;
      watch = (m_phase != 0) && !e_scl(m_phase) && !scl_bus;
      case (m_phase)
        0: if (m_req && bus_free) begin nxt = 1; m_left = HALF; end
        1: if (scl_bus) begin
             m_left--;
             if (m_left == 0) begin
               if (sda_bus) begin nxt = 2; m_left = HOLD; end
               else begin nxt = 4; m_left = HALF; m_second = 0; end
             end
           end
        2: begin m_left--; if (m_left == 0) begin nxt = 3; done_now = 1; end end
        3: if (int_clr) nxt = 0;
        4: begin m_left--; if (m_left == 0) begin nxt = 5; m_left = HALF; end end
        5: if (scl_bus) begin
             m_left--;
             if (m_left == 0) begin
               if (!m_second) begin nxt = 4; m_left = HALF; m_second = 1; end
               else if (sda_bus) begin nxt = 2; m_left = HOLD; end
               else begin nxt = 4; m_left = HALF; m_second = 0; end
             end
           end
        default: nxt = 0;
      endcase
      if (done_now) m_stat = 5'h08;
      else if (m_phase == 3 && int_clr) m_stat = 5'h1F;
      m_req = sta_set || (m_req && !done_now);
      m_int = done_now || (m_int && !int_clr);
      m_stuck = (m_stuck && !int_clr) || (watch && (m_run + 1 >= LIM));
      m_run = watch ? m_run + 1 : 0;
      m_phase = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({sda_oe, scl_oe, intf, pending, stuck, status} ==
          {e_sda(m_phase), e_scl(m_phase), m_int, m_req, m_stuck, m_stat},
          cur, {sda_oe, scl_oe, intf, pending, stuck, status},
          {e_sda(m_phase), e_scl(m_phase), m_int, m_req, m_stuck, m_stat});
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    sta_set = 1'b1; tick(1); sta_set = 1'b0;
  endtask

  task automatic clear_int();
    int_clr = 1'b1; tick(1); int_clr = 1'b0;
  endtask

  task automatic wait_int(input string tag);
    int n = 0;
    while (!intf && n < 500) begin tick(1); n++; end
    chk(intf, tag, intf, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk({sda_oe, scl_oe, intf, pending, stuck, status} == {5'b0, 5'h1F}, "R1",
        {sda_oe, scl_oe, intf, pending, stuck, status}, {5'b0, 5'h1F});

    // R2 request held while bus not free
    cur = "R2";
    pulse_set();
    tick(10);
    chk(pending && !sda_oe && !scl_oe, "R2", {pending, sda_oe, scl_oe}, 3'b100);

    // R3 / R4 normal START
    cur = "R3";
    bus_free = 1'b1;
    tick(4);
    chk(!sda_oe && !scl_oe, "R3", {sda_oe, scl_oe}, 2'b00);
    tick(1);
    chk(sda_oe && !scl_oe, "R3", {sda_oe, scl_oe}, 2'b10);
    cur = "R4";
    tick(2);
    chk(!scl_oe && !intf, "R4", {scl_oe, intf}, 2'b00);
    tick(1);
    chk(scl_oe && sda_oe && intf && !pending && status == 5'h08, "R4",
        {scl_oe, sda_oe, intf, pending, status}, {4'b1110, 5'h08});

    // R10 clear
    cur = "R10";
    clear_int();
    chk(!intf && !sda_oe && !scl_oe && status == 5'h1F, "R10",
        {intf, sda_oe, scl_oe, status}, {3'b000, 5'h1F});

    // R5 / R6 stuck SDA, released during the second pulse pair
    cur = "R6";
    hold_sda = 1'b1;
    pulse_set();
    begin
      int pulses = 0, bad = 0, n = 0;
      bit prev = 0;
      while (!intf && n < 500) begin
        if (scl_oe && !prev && !sda_oe) pulses++;
        if (scl_oe && !intf && sda_oe) bad++;
        if (pulses == 3) hold_sda = 1'b0;
        prev = scl_oe;
        tick(1); n++;
      end
      chk(bad == 0, "R5", bad, 0);
      chk(pulses == 4, "R6", pulses, 4);
      chk(intf && status == 5'h08, "R6", {intf, status}, {1'b1, 5'h08});
    end
    clear_int();

    // R7 clock stretch inside the released half of a pulse
    cur = "R7";
    hold_sda = 1'b1;
    pulse_set();
    begin
      int n = 0;
      while (!scl_oe && n < 100) begin tick(1); n++; end
      while (scl_oe && n < 200) begin tick(1); n++; end
    end
    hold_scl = 1'b1;
    tick(6);
    chk(!scl_oe && !sda_oe, "R7", {scl_oe, sda_oe}, 2'b00);
    hold_scl = 1'b0;
    tick(3);
    chk(!scl_oe, "R7", scl_oe, 0);
    tick(1);
    chk(scl_oe, "R7", scl_oe, 1);
    hold_sda = 1'b0;
    wait_int("R7");
    clear_int();

    // R8 / R9 SCL held low by another device
    cur = "R8";
    hold_scl = 1'b1;
    pulse_set();
    tick(20);
    chk(!sda_oe && !scl_oe, "R8", {sda_oe, scl_oe}, 2'b00);
    chk(stuck, "R9", stuck, 1);
    cur = "R9";
    hold_scl = 1'b0;
    wait_int("R9");
    chk(stuck, "R9", stuck, 1);
    cur = "R10";
    clear_int();
    chk(!stuck && !intf, "R10", {stuck, intf}, 2'b00);

    // R2 repeated START once the bus is granted again
    cur = "R2";
    bus_free = 1'b0;
    pulse_set();
    tick(6);
    chk(!sda_oe && !scl_oe && pending, "R2", {sda_oe, scl_oe, pending}, 3'b001);
    bus_free = 1'b1;
    wait_int("R4");
    clear_int();
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule